// File: doc/BRIEF.md
# Serial Converter Control Sequencer

This block is the digital control side of a two-input, 12-bit sampling converter that acts as the device on a four-wire serial link. A rising edge on the start line launches a conversion whose length is a fixed number of system clock cycles, and the conversion cannot be retriggered. When the conversion ends, a 12-bit sample taken from a parallel test input is recoded and loaded into an output shift register. While the start line is low, the host clocks the result out MSB first and at the same time shifts in a 6-bit configuration word. That word selects the input routing and the output coding for the conversion that follows.

The serial clock, serial input and start line are assumed to be synchronous to the system clock and several times slower than it. Edges of the serial clock are found by comparing it with its value one cycle earlier. The serial output is given as a data bit plus an output enable, and a pad driver outside the block turns these into the three-state pin. If the start line is still high when a conversion finishes, the block goes to sleep. It wakes in the first cycle the line is seen low.

Top module: `adcctl_top`

## Requirements
- R1: A rising edge of `start_in` while idle starts a conversion. `busy` is high for exactly CONV_CYCLES clock cycles, and `conv_done` then pulses high for one cycle as `busy` falls. Further rising edges during a conversion do not restart or lengthen it.
- R2: `sdo_oe` is low whenever `start_in` is high and high whenever `start_in` is low.
- R3: If `start_in` is already low when a conversion ends, the result MSB is on `sdo_dat` in the first cycle after `busy` falls, and `asleep` stays low.
- R4: If `start_in` is high when a conversion ends, `asleep` goes high with `conv_done`. It returns low in the first cycle that `start_in` is sampled low.
- R5: While `start_in` is low and no conversion runs, each falling edge of `sck_in` advances `sdo_dat` by one bit. A full frame gives 12 bits, MSB first and LSB last. While a conversion runs, `sdo_dat` does not change until the result is loaded.
- R6: `cfg_in` is captured on the first 6 rising edges of `sck_in`, counted from the later of `start_in` falling and the conversion ending. The first captured bit becomes word bit 5 and the sixth becomes bit 0. Rising edges after the sixth do not alter the word.
- R7: Word bit 5 (single/differential) and bit 4 (odd/sign) set the routing. With 00, `pos_ch1`=0 and `neg_sel`=1. With 01, `pos_ch1`=1 and `neg_sel`=0. With 10, `pos_ch1`=0 and `neg_sel`=2. With 11, `pos_ch1`=1 and `neg_sel`=2. Here `neg_sel` 0 means input 0, 1 means input 1 and 2 means ground. Bits 3, 2 and 0 have no effect.
- R8: Word bit 1 is the unipolar flag. When it is 1, the shifted result equals `sample_in`. When it is 0, the result is `sample_in` with its MSB inverted (offset binary turned into two's complement).
- R9: A captured word becomes active at the next conversion start. It shows on `pos_ch1`, `neg_sel` and `unipolar` from then on and governs the coding of that conversion's result.
- R10: `acquire` rises once the sixth configuration bit has been captured with no conversion running. It is low before that and is cleared by the next conversion start.
- R11: After reset, `busy`, `conv_done`, `asleep`, `acquire`, `sdo_dat`, `pos_ch1` and `unipolar` are 0 and `neg_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_in | input | 1 | Conversion start line; its level also gates the serial output |
| sck_in | input | 1 | Serial clock from the host |
| cfg_in | input | 1 | Serial configuration bit from the host |
| sample_in | input | 12 | Parallel test sample, straight binary, taken at conversion end |
| sdo_dat | output | 1 | Serial result bit |
| sdo_oe | output | 1 | Output enable for the serial result pad |
| conv_done | output | 1 | One-cycle pulse at conversion end |
| busy | output | 1 | Conversion in progress |
| asleep | output | 1 | Sleep state |
| acquire | output | 1 | Configuration complete, input acquisition under way |
| pos_ch1 | output | 1 | Active routing: positive side is input 1 |
| neg_sel | output | 2 | Active routing: negative side (0 input 0, 1 input 1, 2 ground) |
| unipolar | output | 1 | Active coding: straight binary when 1 |

## Verification
The hardest cases to reach from the ports depend on the order of two edges on the same start line. One is the line falling during a conversion rather than after it. The other is the line rising again mid-conversion, which is a retrigger that must be ignored. The stimulus table has a flag per frame that selects the early-fall path or the hold-high-then-sleep path, so both endings alternate. A directed test toggles the start line inside a running conversion and counts cycles to `conv_done`. Because a configuration word takes effect one conversion later, the bench carries the previous word forward when it predicts both the routing outputs and the result coding. It also drives inverted bits after the sixth serial clock edge so that late edges would visibly corrupt the word.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;

  localparam int CFG_BITS = 6;
  localparam int SD_POS   = 5;
  localparam int OS_POS   = 4;
  localparam int UNI_POS  = 1;

  typedef enum logic [1:0] {
    NEG_CH0 = 2'd0,
    NEG_CH1 = 2'd1,
    NEG_GND = 2'd2
  } neg_sel_e;

  typedef struct packed {
    logic     pos_ch1;
    neg_sel_e neg;
    logic     unipolar;
  } route_t;

  // Configuration word to routing and coding settings.
  function automatic route_t decode_cfg(input logic [CFG_BITS-1:0] w);
    route_t r;
    r.unipolar = w[UNI_POS];
    r.pos_ch1  = w[OS_POS];
    if (w[SD_POS]) r.neg = NEG_GND;
    else           r.neg = w[OS_POS] ? NEG_CH0 : NEG_CH1;
    return r;
  endfunction

endpackage

// File: rtl/adcctl_seq.sv
module adcctl_seq #(
  parameter int CONV_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  output logic start_fall,
  output logic conv_start,
  output logic fin,
  output logic busy,
  output logic conv_done,
  output logic asleep
);
  localparam int TMR_W = $clog2(CONV_CYCLES + 1);

  logic             start_q;
  logic [TMR_W-1:0] tmr;
  logic             start_rise;

  assign start_rise = start_in & ~start_q;
  assign start_fall = ~start_in & start_q;
  assign conv_start = start_rise & ~busy;
  assign fin        = busy & (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      busy      <= 1'b0;
      tmr       <= '0;
      conv_done <= 1'b0;
      asleep    <= 1'b0;
    end else begin
      start_q   <= start_in;
      conv_done <= fin;
      if (!start_in) asleep <= 1'b0;
      if (fin) begin
        busy <= 1'b0;
        if (start_in) asleep <= 1'b1;
      end else if (busy) begin
        tmr <= tmr - 1'b1;
      end else if (conv_start) begin
        busy <= 1'b1;
        tmr  <= TMR_W'(CONV_CYCLES - 1);
      end
    end
  end

endmodule

// File: rtl/adcctl_cfg.sv
module adcctl_cfg
  import adcctl_pkg::*;
#(
  parameter int CNT_W = $clog2(CFG_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_clr,
  input  logic                sck_rise,
  input  logic                xfer_en,
  input  logic                cfg_in,
  input  logic                conv_start,
  input  logic                busy,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic [CFG_BITS-1:0] pend_word,
  output route_t              route,
  output logic                acquire
);
  logic [CFG_BITS-1:0] shw;
  logic [CFG_BITS-1:0] act_word;
  logic [CFG_BITS-1:0] shw_next;

  assign shw_next = {shw[CFG_BITS-2:0], cfg_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shw       <= '0;
      pend_word <= '0;
    end else if (frame_clr) begin
      bit_cnt <= '0;
    end else if (sck_rise && xfer_en && (bit_cnt < CNT_W'(CFG_BITS))) begin
      shw     <= shw_next;
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(CFG_BITS - 1)) pend_word <= shw_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          act_word <= '0;
    else if (conv_start) act_word <= pend_word;
  end

  assign route   = decode_cfg(act_word);
  assign acquire = (bit_cnt == CNT_W'(CFG_BITS)) & ~busy;

endmodule

// File: rtl/adcctl_shift.sv
module adcctl_shift #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              unipolar,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo_dat
);
  logic [DATA_W-1:0] shreg;

  // Straight binary passes through; bipolar flips the MSB.
  function automatic logic [DATA_W-1:0] recode(input logic [DATA_W-1:0] s,
                                               input logic uni);
    return uni ? s : {~s[DATA_W-1], s[DATA_W-2:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= recode(sample, unipolar);
    else if (shift) shreg <= {shreg[DATA_W-2:0], 1'b0};
  end

  assign sdo_dat = shreg[DATA_W-1];

endmodule

// File: rtl/adcctl_top.sv
module adcctl_top
  import adcctl_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int DATA_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_in,
  input  logic              sck_in,
  input  logic              cfg_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo_dat,
  output logic              sdo_oe,
  output logic              conv_done,
  output logic              busy,
  output logic              asleep,
  output logic              acquire,
  output logic              pos_ch1,
  output logic [1:0]        neg_sel,
  output logic              unipolar
);
  localparam int CNT_W = $clog2(CFG_BITS + 1);

  logic                sck_q;
  logic                sck_rise;
  logic                sck_fall;
  logic                xfer_en;
  logic                start_fall;
  logic                conv_start;
  logic                fin_w;
  logic                frame_clr;
  logic [CNT_W-1:0]    cfg_cnt_w;
  logic [CFG_BITS-1:0] cfg_pend_w;
  route_t              route;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_in;
  end

  assign sck_rise  = sck_in & ~sck_q;
  assign sck_fall  = ~sck_in & sck_q;
  assign xfer_en   = ~start_in & ~busy;
  assign frame_clr = start_fall | fin_w;
  assign sdo_oe    = ~start_in;

  adcctl_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_in   (start_in),
    .start_fall (start_fall),
    .conv_start (conv_start),
    .fin        (fin_w),
    .busy       (busy),
    .conv_done  (conv_done),
    .asleep     (asleep)
  );

  adcctl_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clr  (frame_clr),
    .sck_rise   (sck_rise),
    .xfer_en    (xfer_en),
    .cfg_in     (cfg_in),
    .conv_start (conv_start),
    .busy       (busy),
    .bit_cnt    (cfg_cnt_w),
    .pend_word  (cfg_pend_w),
    .route      (route),
    .acquire    (acquire)
  );

  adcctl_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fin_w),
    .shift    (sck_fall & xfer_en),
    .unipolar (route.unipolar),
    .sample   (sample_in),
    .sdo_dat  (sdo_dat)
  );

  assign pos_ch1  = route.pos_ch1;
  assign neg_sel  = route.neg;
  assign unipolar = route.unipolar;

endmodule

// File: rtl/adcctl_chk.sv
module adcctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_in,
  input logic       busy,
  input logic       fin,
  input logic       conv_done,
  input logic       asleep,
  input logic       sdo_dat,
  input logic [2:0] cfg_cnt,
  input logic [5:0] cfg_pend
);

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy); // R1

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fin) |=> (conv_done && !busy)); // R1

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && start_in) |=> asleep); // R4

  AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !start_in |=> !asleep); // R4

  AST_NO_SHIFT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(sdo_dat)); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cnt == 3'd6) |=> $stable(cfg_pend)); // R6

endmodule

bind adcctl_top adcctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_in  (start_in),
  .busy      (busy),
  .fin       (fin_w),
  .conv_done (conv_done),
  .asleep    (asleep),
  .sdo_dat   (sdo_dat),
  .cfg_cnt   (cfg_cnt_w),
  .cfg_pend  (cfg_pend_w)
);

// File: tb/sim_adcctl_top.sv
`timescale 1ns/1ps
module sim_adcctl_top;
  localparam int CONV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_in = 1'b0;
  logic        sck_in = 1'b0;
  logic        cfg_in = 1'b0;
  logic [11:0] sample_in = '0;
  logic        sdo_dat, sdo_oe, conv_done, busy, asleep, acquire;
  logic        pos_ch1, unipolar;
  logic [1:0]  neg_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adcctl_top #(.CONV_CYCLES(CONV), .DATA_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .sck_in(sck_in),
    .cfg_in(cfg_in), .sample_in(sample_in), .sdo_dat(sdo_dat),
    .sdo_oe(sdo_oe), .conv_done(conv_done), .busy(busy), .asleep(asleep),
    .acquire(acquire), .pos_ch1(pos_ch1), .neg_sel(neg_sel),
    .unipolar(unipolar)
  );

  // {early_fall, cfg[5:0], sample[11:0]}
  localparam logic [18:0] VEC [0:5] = '{
    {1'b1, 6'b000010, 12'hA5C},
    {1'b0, 6'b010000, 12'h3F0},
    {1'b1, 6'b100010, 12'h800},
    {1'b0, 6'b111111, 12'hFFF},
    {1'b1, 6'b001101, 12'h001},
    {1'b0, 6'b000000, 12'h7FF}
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_code(input logic [11:0] s,
                                              input logic [5:0] w);
    if (w[1]) return s;
    return s ^ 12'h800;
  endfunction

  function automatic logic [3:0] expect_route(input logic [5:0] w);
    logic [1:0] ns;
    case (w[5:4])
      2'b00:   ns = 2'd1;
      2'b01:   ns = 2'd0;
      default: ns = 2'd2;
    endcase
    return {w[4], ns, w[1]};
  endfunction

  task automatic wait_idle();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (busy && guard < 1000);
  endtask

  task automatic run_frame(input logic [5:0] cfg, input logic [11:0] smp,
                           input logic early, input logic [5:0] prev,
                           output logic [11:0] got);
    sample_in = smp;
    start_in  = 1'b1;
    @(negedge clk);
    check("R2 oe off while start high", sdo_oe, 1'b0);
    check("R9 R7 active routing", {pos_ch1, neg_sel, unipolar},
          expect_route(prev));
    check("R10 acquire cleared at start", acquire, 1'b0);
    if (early) begin
      repeat (3) @(negedge clk);
      start_in = 1'b0;
      wait_idle();
      check("R3 no sleep when low at end", asleep, 1'b0);
    end else begin
      wait_idle();
      check("R4 sleep when high at end", asleep, 1'b1);
      start_in = 1'b0;
      @(negedge clk);
      check("R4 wake on low", asleep, 1'b0);
      check("R2 oe on while start low", sdo_oe, 1'b1);
    end
    for (int i = 0; i < 12; i++) begin
      got[11-i] = sdo_dat;
      cfg_in = (i < 6) ? cfg[5-i] : ~cfg[11-i];
      if (i == 5) check("R10 acquire low before sixth bit", acquire, 1'b0);
      sck_in = 1'b1;
      repeat (2) @(negedge clk);
      if (i == 5) check("R10 acquire after sixth bit", acquire, 1'b1);
      sck_in = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0]  prev;
    logic [11:0] got;
    int          cyc;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", busy, 1'b0);
    check("R11 done", conv_done, 1'b0);
    check("R11 asleep", asleep, 1'b0);
    check("R11 acquire", acquire, 1'b0);
    check("R11 sdo", sdo_dat, 1'b0);
    check("R11 routing", {pos_ch1, neg_sel, unipolar}, 4'b0010);

    prev = 6'b000000;
    for (int k = 0; k < 6; k++) begin
      run_frame(VEC[k][17:12], VEC[k][11:0], VEC[k][18], prev, got);
      check("R5 R8 shifted result", got, expect_code(VEC[k][11:0], prev));
      prev = VEC[k][17:12];
    end

    // R1: retrigger during a conversion is ignored
    cyc = 0;
    start_in = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 4) start_in = 1'b0;
      if (cyc == 6) start_in = 1'b1;
    end while (!conv_done && cyc < 1000);
    check("R1 conversion length with retrigger", cyc, CONV + 1);
    check("R1 busy low at done", busy, 1'b0);
    check("R4 asleep after retrigger run", asleep, 1'b1);
    @(negedge clk);
    check("R1 done is one pulse", conv_done, 1'b0);
    check("R9 routing from last word", {pos_ch1, neg_sel, unipolar},
          expect_route(prev));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule